// File: doc/BRIEF.md
# Performance Event Counter Bank with Freeze Controls

This block is a bank of up-counting performance event counters for a processor core. Each counter picks one line from a vector of single-cycle event pulses and adds one for every pulse it sees. Each counter also has a set of freeze conditions. A counter can be held outright. It can also be held while the core is in supervisor mode, or while it is in user mode. Two more conditions hold it while a per-task mark flag is 1, or while that flag is 0. The counters can therefore be limited to the privilege level and the tasks of interest.

A global control word has three bits. One freezes the whole bank. One enables the interrupt request. One makes the bank freeze itself as soon as any counter raises an enabled overflow condition, so that every counter value stays fixed at that moment for software to collect. An external mask input also stops all counting, so software can arm the counters and release them later by clearing the mask. Software sets a sampling period N by loading 0x80000000 − N into a counter. Bit 31 then becomes 1 after N events, and that raises the overflow condition.

Registers are reached through a plain write port and a read port with no side effects. The port uses a 4-bit address.

Top module: `evt_ctr_bank`

## Requirements
- R1: Each of the four 32-bit counters adds exactly one in the clock edge that samples a qualifying pulse on its selected event line. Only a register write can change a counter by any other amount.
- R2: The event select field sits in control word bits [10:8] and picks one of eight event inputs. Pulses on any other event line leave the counter unchanged.
- R3: The freeze bits of a control word are bit 0 (hold always), bit 1 (hold while the supervisor input is 1), bit 2 (hold while the supervisor input is 0), bit 3 (hold while mark is 1) and bit 4 (hold while mark is 0). A pulse is counted only when none of these bits applies.
- R4: When control word bit 5 (condition enable) is set and counter bit 31 is 1, that counter has an overflow condition. A register write that loads a value with bit 31 clear removes the condition in the next cycle.
- R5: While global bit 0 (freeze all) is 1, no counter increments.
- R6: irq_o is 1 exactly when global bit 1 (interrupt enable) is 1 and at least one counter has an overflow condition.
- R7: While global bit 2 (freeze on condition) is 1 and any overflow condition exists, counting stops in that same cycle. On the next edge, global bit 0 becomes 1.
- R8: While mask_i is 1, no counter increments. Counting resumes once it is 0.
- R9: A counter loaded with 0x80000000 − N and enabled for the condition reaches the overflow condition after N counted events and not before.
- R10: After reset, all counters are 0. Every control word reads 0x0000001F (all freezes set, condition enable clear, event 0). The global word reads 0x00000001 (frozen) and irq_o is 0.
- R11: The address map is: counters at 0–3, control words at 4–7, the global word at 8, and 0 for any other address. A write to a counter in the same cycle as a counted event stores the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event pulse inputs |
| sup_mode_i | input | 1 | 1 while the core runs in supervisor mode |
| mark_i | input | 1 | Per-task mark flag |
| mask_i | input | 1 | External count mask, 1 stops all counting |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for both read and write |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, combinational |
| cnt_o | output | 128 | All counter values, counter 0 in the low 32 bits |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: four counters of 32 bits and eight event lines. With these values, counter 0 and counter 1 can share one event line, so the same-cycle bank freeze shows up as a counter that stops one pulse after its neighbour crosses bit 31. The vector table walks each freeze bit under both levels of its mode or mark input, and it also tries an unselected event line. Directed cases then check the sampling period just before and just at the crossing, the write-over-increment collision, the clearing of the condition by a write, and the mask release.

// File: rtl/evt_bank_pkg.sv
package evt_bank_pkg;
    // control word bit positions
    localparam int CTL_HOLD    = 0;
    localparam int CTL_SUP     = 1;
    localparam int CTL_USR     = 2;
    localparam int CTL_MK1     = 3;
    localparam int CTL_MK0     = 4;
    localparam int CTL_CEN     = 5;
    localparam int CTL_SEL_LSB = 8;
    // global word bit positions
    localparam int GLB_FRZ = 0;
    localparam int GLB_IRQ = 1;
    localparam int GLB_FOC = 2;

    typedef struct packed {
        logic cond_en;
        logic stop_mk0;
        logic stop_mk1;
        logic stop_usr;
        logic stop_sup;
        logic hold;
    } frz_cfg_t;

    typedef struct packed {
        logic frz_on_cond;
        logic irq_en;
        logic freeze_all;
    } glb_cfg_t;

    localparam frz_cfg_t FRZ_RESET = '{cond_en: 1'b0, stop_mk0: 1'b1, stop_mk1: 1'b1,
                                       stop_usr: 1'b1, stop_sup: 1'b1, hold: 1'b1};

    function automatic logic is_blocked(frz_cfg_t c, logic sup, logic mark);
        return c.hold | (sup & c.stop_sup) | (~sup & c.stop_usr)
             | (mark & c.stop_mk1) | (~mark & c.stop_mk0);
    endfunction
endpackage

// File: rtl/evt_ctr_slot.sv
module evt_ctr_slot
    import evt_bank_pkg::*;
#(
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 8,
    parameter int DATA_W  = 32,
    localparam int SEL_W  = $clog2(NUM_EVT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic              sup_i,
    input  logic              mark_i,
    input  logic              mask_i,
    input  logic              gfreeze_i,
    input  logic              ctl_we_i,
    input  frz_cfg_t          ctl_cfg_i,
    input  logic [SEL_W-1:0]  ctl_sel_i,
    input  logic              cnt_we_i,
    input  logic [CTR_W-1:0]  cnt_wdata_i,
    output logic [CTR_W-1:0]  cnt_o,
    output logic [DATA_W-1:0] ctl_o,
    output logic              cond_o
);
    logic [CTR_W-1:0] cnt_q;
    frz_cfg_t         cfg_q;
    logic [SEL_W-1:0] sel_q;
    logic             inc;

    assign inc = evt_i[sel_q] & ~is_blocked(cfg_q, sup_i, mark_i) & ~gfreeze_i & ~mask_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= FRZ_RESET;
            sel_q <= '0;
        end else if (ctl_we_i) begin
            cfg_q <= ctl_cfg_i;
            sel_q <= ctl_sel_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (cnt_we_i) cnt_q <= cnt_wdata_i;
        else if (inc)      cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        ctl_o = '0;
        ctl_o[CTL_HOLD] = cfg_q.hold;
        ctl_o[CTL_SUP]  = cfg_q.stop_sup;
        ctl_o[CTL_USR]  = cfg_q.stop_usr;
        ctl_o[CTL_MK1]  = cfg_q.stop_mk1;
        ctl_o[CTL_MK0]  = cfg_q.stop_mk0;
        ctl_o[CTL_CEN]  = cfg_q.cond_en;
        ctl_o[CTL_SEL_LSB +: SEL_W] = sel_q;
    end

    assign cnt_o  = cnt_q;
    assign cond_o = cfg_q.cond_en & cnt_q[CTR_W-1];

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_we_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.hold && !cnt_we_i) |=> $stable(cnt_q));
    // R8
    cnt_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_i && !cnt_we_i) |=> $stable(cnt_q));
    // R5
    gfrz_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (gfreeze_i && !cnt_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_bank_glb.sv
module evt_bank_glb
    import evt_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  glb_cfg_t          wcfg_i,
    input  logic              any_cond_i,
    output logic              freeze_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] word_o
);
    glb_cfg_t cfg_q;
    glb_cfg_t cfg_d;

    always_comb begin
        cfg_d = we_i ? wcfg_i : cfg_q;
        if (cfg_q.frz_on_cond && any_cond_i) cfg_d.freeze_all = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '{frz_on_cond: 1'b0, irq_en: 1'b0, freeze_all: 1'b1};
        else     cfg_q <= cfg_d;
    end

    assign freeze_o = cfg_q.freeze_all | (cfg_q.frz_on_cond & any_cond_i);
    assign irq_o    = cfg_q.irq_en & any_cond_i;

    always_comb begin
        word_o = '0;
        word_o[GLB_FRZ] = cfg_q.freeze_all;
        word_o[GLB_IRQ] = cfg_q.irq_en;
        word_o[GLB_FOC] = cfg_q.frz_on_cond;
    end

    // R7
    gfrz_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.frz_on_cond && any_cond_i) |=> cfg_q.freeze_all);
endmodule

// File: rtl/evt_bank_rdmux.sv
module evt_bank_rdmux #(
    parameter int NUM_CTRS = 4,
    parameter int CTR_W    = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [NUM_CTRS*CTR_W-1:0]  cnt_i,
    input  logic [NUM_CTRS*DATA_W-1:0] ctl_i,
    input  logic [DATA_W-1:0]          glb_i,
    output logic [DATA_W-1:0]          rdata_o
);
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_CTRS; i++) begin
            if (addr_i == ADDR_W'(i))
                rdata_o = DATA_W'(cnt_i[i*CTR_W +: CTR_W]);
            if (addr_i == ADDR_W'(NUM_CTRS + i))
                rdata_o = ctl_i[i*DATA_W +: DATA_W];
        end
        if (addr_i == ADDR_W'(2*NUM_CTRS)) rdata_o = glb_i;
    end
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
    import evt_bank_pkg::*;
#(
    parameter int NUM_CTRS = 4,
    parameter int CTR_W    = 32,
    parameter int NUM_EVT  = 8,
    localparam int DATA_W  = 32,
    localparam int ADDR_W  = $clog2(2*NUM_CTRS + 1),
    localparam int SEL_W   = $clog2(NUM_EVT)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_EVT-1:0]        evt_i,
    input  logic                      sup_mode_i,
    input  logic                      mark_i,
    input  logic                      mask_i,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [DATA_W-1:0]         rd_data_o,
    output logic [NUM_CTRS*CTR_W-1:0] cnt_o,
    output logic                      irq_o
);
    logic [NUM_CTRS-1:0]        cond;
    logic [NUM_CTRS*DATA_W-1:0] ctl_words;
    logic [DATA_W-1:0]          glb_word;
    logic                       gfreeze;
    frz_cfg_t                   wr_ctl;
    glb_cfg_t                   wr_glb;

    assign wr_ctl = '{cond_en: wdata_i[CTL_CEN], stop_mk0: wdata_i[CTL_MK0],
                      stop_mk1: wdata_i[CTL_MK1], stop_usr: wdata_i[CTL_USR],
                      stop_sup: wdata_i[CTL_SUP], hold: wdata_i[CTL_HOLD]};
    assign wr_glb = '{frz_on_cond: wdata_i[GLB_FOC], irq_en: wdata_i[GLB_IRQ],
                      freeze_all: wdata_i[GLB_FRZ]};

    for (genvar g = 0; g < NUM_CTRS; g++) begin : g_slot
        evt_ctr_slot #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .evt_i      (evt_i),
            .sup_i      (sup_mode_i),
            .mark_i     (mark_i),
            .mask_i     (mask_i),
            .gfreeze_i  (gfreeze),
            .ctl_we_i   (wr_en_i && addr_i == ADDR_W'(NUM_CTRS + g)),
            .ctl_cfg_i  (wr_ctl),
            .ctl_sel_i  (wdata_i[CTL_SEL_LSB +: SEL_W]),
            .cnt_we_i   (wr_en_i && addr_i == ADDR_W'(g)),
            .cnt_wdata_i(wdata_i[CTR_W-1:0]),
            .cnt_o      (cnt_o[g*CTR_W +: CTR_W]),
            .ctl_o      (ctl_words[g*DATA_W +: DATA_W]),
            .cond_o     (cond[g])
        );
    end

    evt_bank_glb #(.DATA_W(DATA_W)) u_glb (
        .clk       (clk),
        .rst       (rst),
        .we_i      (wr_en_i && addr_i == ADDR_W'(2*NUM_CTRS)),
        .wcfg_i    (wr_glb),
        .any_cond_i(|cond),
        .freeze_o  (gfreeze),
        .irq_o     (irq_o),
        .word_o    (glb_word)
    );

    evt_bank_rdmux #(.NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .addr_i (addr_i),
        .cnt_i  (cnt_o),
        .ctl_i  (ctl_words),
        .glb_i  (glb_word),
        .rdata_o(rd_data_o)
    );

    // R6
    irq_cond_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (cond != '0));
endmodule

// File: tb/evt_ctr_bank_test.sv
module evt_ctr_bank_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  evt_i;
    logic        sup_mode_i, mark_i, mask_i, wr_en_i;
    logic [3:0]  addr_i;
    logic [31:0] wdata_i;
    logic [31:0] rd_data_o;
    logic [127:0] cnt_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    evt_ctr_bank uut (.*);

    // vector: sel[28:26] pulse[25:23] frz[22:18] sup[17] mark[16] n[15:8] exp[7:0]
    localparam int NV = 11;
    localparam logic [28:0] VEC [NV] = '{
        {3'd2, 3'd2, 5'b00000, 1'b0, 1'b0, 8'd5, 8'd5},  // R1 free counting
        {3'd5, 3'd5, 5'b00001, 1'b0, 1'b0, 8'd4, 8'd0},  // R3 hold
        {3'd1, 3'd1, 5'b00010, 1'b1, 1'b0, 8'd3, 8'd0},  // R3 stop in sup
        {3'd1, 3'd1, 5'b00010, 1'b0, 1'b0, 8'd3, 8'd3},  // R3 sup stop, user mode
        {3'd3, 3'd3, 5'b00100, 1'b0, 1'b0, 8'd2, 8'd0},  // R3 stop in user
        {3'd3, 3'd3, 5'b00100, 1'b1, 1'b0, 8'd2, 8'd2},  // R3 user stop, sup mode
        {3'd0, 3'd0, 5'b01000, 1'b0, 1'b1, 8'd4, 8'd0},  // R3 stop mark 1
        {3'd0, 3'd0, 5'b01000, 1'b0, 1'b0, 8'd4, 8'd4},
        {3'd7, 3'd7, 5'b10000, 1'b0, 1'b0, 8'd3, 8'd0},  // R3 stop mark 0
        {3'd7, 3'd7, 5'b10000, 1'b0, 1'b1, 8'd3, 8'd3},
        {3'd4, 3'd6, 5'b00000, 1'b0, 1'b0, 8'd3, 8'd0}   // R2 other line ignored
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        addr_i = a;
        #1;
        v = rd_data_o;
    endtask

    task automatic pulse(int line, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evt_i = 8'(1 << line);
            @(negedge clk);
            evt_i = '0;
        end
    endtask

    function automatic logic [31:0] ctlw(int sel, logic [4:0] frz, logic cen);
        return (32'(sel) << 8) | (32'(cen) << 5) | 32'(frz);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; evt_i = '0; sup_mode_i = 0; mark_i = 0; mask_i = 0;
        wr_en_i = 0; addr_i = '0; wdata_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        rd(4'd0, v); check("R10 cnt0", v, 32'h0);
        rd(4'd3, v); check("R10 cnt3", v, 32'h0);
        rd(4'd4, v); check("R10 ctl0", v, 32'h1F);
        rd(4'd7, v); check("R10 ctl3", v, 32'h1F);
        rd(4'd8, v); check("R10 glb", v, 32'h1);
        check("R10 irq", {31'd0, irq_o}, 32'h0);
        rd(4'd9, v); check("R11 unmapped", v, 32'h0);

        wr(4'd8, 32'h0);
        // table of freeze and select vectors
        for (int i = 0; i < NV; i++) begin
            wr(4'd4, ctlw(int'(VEC[i][28:26]), VEC[i][22:18], 1'b0));
            wr(4'd0, 32'h0);
            sup_mode_i = VEC[i][17]; mark_i = VEC[i][16];
            pulse(int'(VEC[i][25:23]), int'(VEC[i][15:8]));
            rd(4'd0, v);
            check($sformatf("R1/R2/R3 vector %0d", i), v, 32'(VEC[i][7:0]));
        end
        sup_mode_i = 0; mark_i = 0;
        wr(4'd4, ctlw(0, 5'b0, 1'b0));
        rd(4'd4, v); check("R2 ctl readback", v, 32'h0);

        // R5 freeze all
        wr(4'd0, 32'd10);
        wr(4'd8, 32'h1);
        pulse(0, 3);
        rd(4'd0, v); check("R5 frozen", v, 32'd10);
        wr(4'd8, 32'h0);

        // R8 mask
        mask_i = 1; pulse(0, 2);
        rd(4'd0, v); check("R8 masked", v, 32'd10);
        mask_i = 0; pulse(0, 2);
        rd(4'd0, v); check("R8 released", v, 32'd12);

        // R11 write wins over increment
        @(negedge clk);
        wr_en_i = 1; addr_i = 4'd0; wdata_i = 32'd500; evt_i = 8'h01;
        @(negedge clk);
        wr_en_i = 0; evt_i = '0;
        rd(4'd0, v); check("R11 write wins", v, 32'd500);

        // R9 period N=3, R6 irq, R4 condition
        wr(4'd4, ctlw(0, 5'b0, 1'b1));
        wr(4'd0, 32'h8000_0000 - 32'd3);
        wr(4'd8, 32'h2);
        pulse(0, 2);
        rd(4'd0, v); check("R9 before crossing", v, 32'h7FFF_FFFF);
        check("R9 no irq yet", {31'd0, irq_o}, 32'h0);
        pulse(0, 1);
        rd(4'd0, v); check("R9 crossing", v, 32'h8000_0000);
        check("R6 irq raised", {31'd0, irq_o}, 32'h1);
        wr(4'd8, 32'h0);
        check("R6 irq disabled", {31'd0, irq_o}, 32'h0);
        wr(4'd8, 32'h2);
        wr(4'd0, 32'd5);
        check("R4 write clears cond", {31'd0, irq_o}, 32'h0);

        // R7 freeze on condition
        wr(4'd5, ctlw(0, 5'b0, 1'b0));
        wr(4'd1, 32'd100);
        wr(4'd0, 32'h7FFF_FFFF);
        wr(4'd8, 32'h6);
        pulse(0, 1);
        rd(4'd1, v); check("R7 neighbour counted", v, 32'd101);
        pulse(0, 2);
        rd(4'd1, v); check("R7 neighbour frozen", v, 32'd101);
        rd(4'd0, v); check("R7 crossing counter held", v, 32'h8000_0000);
        rd(4'd8, v); check("R7 freeze bit set", v, 32'h7);
        check("R7 irq", {31'd0, irq_o}, 32'h1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule